// File: doc/BRIEF.md
# Event-Driven Output Set/Clear Unit

This unit drives a bank of output bits (sixteen by default) from a vector of single-cycle event strobes (sixteen by default). Each output has two event masks. Any strobe that hits the first mask drives the output high. Any strobe that hits the second mask drives it low. When strobes from both masks hit the same output in the same cycle, a two-bit per-output action settles the result: keep the level, force it high, force it low, or invert it. Used as a PWM back end, a "period" event and a "duty" event are routed to each output. With normal polarity the period event raises the output, the duty event lowers it, and the tie action is "force high", so a duty equal to the period gives a steady high level. Inverted polarity swaps the two events and uses "force low".

Each output is a two-state machine with states `LVL_LOW` and `LVL_HIGH`. From `LVL_LOW` the RAISE transition is taken on a set command or a toggle command. From `LVL_HIGH` the DROP transition is taken on a clear command or a toggle command. Every other command takes the HOLD transition back to the same state. The command for each cycle is one of `CMD_HOLD`, `CMD_SET`, `CMD_CLEAR` or `CMD_TOGGLE`. It is built from the two mask hits and the tie action. The state register is the output register, so a strobe moves the pin one clock later.

Software programs the unit through a one-cycle write port. The upper two address bits select the region. The lower bits select the output.

Top module: `evo_setclr_unit`

## Requirements
- R1: After reset every output is 0, every mask is 0 and every tie action is 0 (keep). A strobe applied right after reset, before any tie action is written, leaves the outputs at 0.
- R2: When a strobe hits an output's set mask and none hits its clear mask, the output is 1 after the next clock edge.
- R3: When a strobe hits an output's clear mask and none hits its set mask, the output is 0 after the next clock edge.
- R4: When no strobe hits either mask of an output, the output keeps its level.
- R5: When strobes hit both masks of output i, the tie field at `tie_word[2i+1:2i]` decides the result: 0 keeps the level, 1 gives 1, 2 gives 0, 3 inverts the level.
- R6: An output whose two masks are both 0 keeps its current level whatever strobes arrive.
- R7: A write with `wr_addr[5:4]`=0 loads the set mask of output `wr_addr[3:0]` from `wr_data[15:0]`. A value of 1 loads the clear mask the same way. A value of 2 loads the whole tie word from `wr_data[31:0]`. A value of 3 changes nothing. A write acts on strobes from the following cycle onward, so a strobe in the same cycle as the write sees the old setting.
- R8: With the period event in the set mask, the duty event in the clear mask and tie action 1, coinciding period and duty strobes keep the output at 1, and a duty strobe on its own brings the output to 0.
- R9: With the duty event in the set mask, the period event in the clear mask and tie action 2, a duty strobe on its own brings the output to 1, and coinciding strobes keep the output at 0.
- R10: Each output follows only its own masks and its own tie field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Region (bits 5:4) and output index (bits 3:0) |
| wr_data | input | 32 | Write data |
| ev_strobe | input | 16 | One bit per event, high for one cycle when the event fires |
| pwm_out | output | 16 | Registered output levels |

## Verification
Two things can happen to one output in the same cycle. Strobes can hit both its set mask and its clear mask. A register write can also arrive together with a strobe. The stimulus table drives the period and duty events together on outputs programmed with each of the four tie actions. It repeats the collision so that the toggle case shows both directions, and the expected levels are written out by hand. A directed test loads a new set mask in the same cycle as a strobe that hits the old mask. The check is that the old mask still decides that edge and the new mask decides the next one.

// File: rtl/evo_pkg.sv
package evo_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_HIGH   = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_INVERT = 2'd3
    } tie_act_e;

    typedef enum logic [1:0] {
        RGN_SET_MASK = 2'd0,
        RGN_CLR_MASK = 2'd1,
        RGN_TIE_WORD = 2'd2,
        RGN_UNUSED   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_SET,
        CMD_CLEAR,
        CMD_TOGGLE
    } cmd_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

endpackage

// File: rtl/evo_regfile.sv
module evo_regfile
    import evo_pkg::*;
#(
    parameter int N_OUT  = 16,
    parameter int N_EV   = 16,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [N_OUT*N_EV-1:0]   set_flat,
    output logic [N_OUT*N_EV-1:0]   clr_flat,
    output logic [2*N_OUT-1:0]      tie_word
);

    region_e          rgn;
    logic [IDX_W-1:0] idx;

    assign rgn = region_e'(wr_addr[ADDR_W-1 -: 2]);
    assign idx = wr_addr[IDX_W-1:0];

    for (genvar i = 0; i < N_OUT; i++) begin : g_mask
        logic [N_EV-1:0] set_q;
        logic [N_EV-1:0] clr_q;
        logic            hit_idx;

        assign hit_idx = wr_en && (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                set_q <= '0;
            end else if (hit_idx && rgn == RGN_SET_MASK) begin
                set_q <= wr_data[N_EV-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                clr_q <= '0;
            end else if (hit_idx && rgn == RGN_CLR_MASK) begin
                clr_q <= wr_data[N_EV-1:0];
            end
        end

        assign set_flat[i*N_EV +: N_EV] = set_q;
        assign clr_flat[i*N_EV +: N_EV] = clr_q;
    end

    logic [2*N_OUT-1:0] tie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tie_q <= '0;
        end else if (wr_en && rgn == RGN_TIE_WORD) begin
            tie_q <= wr_data[2*N_OUT-1:0];
        end
    end

    assign tie_word = tie_q;

    AST_UNUSED_REGION_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == RGN_UNUSED) |=> ($stable(tie_q) && $stable(set_flat) && $stable(clr_flat))) // R7
        else $error("write to unused region changed state");

    AST_TIE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == RGN_TIE_WORD) |=> (tie_q == $past(wr_data[2*N_OUT-1:0]))) // R7
        else $error("tie word write lost");

endmodule

// File: rtl/evo_chan.sv
module evo_chan
    import evo_pkg::*;
#(
    parameter int N_EV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] set_mask,
    input  logic [N_EV-1:0] clr_mask,
    input  logic [1:0]      tie_field,
    input  logic [N_EV-1:0] ev_strobe,
    output logic            level
);

    logic     hit_set;
    logic     hit_clr;
    tie_act_e tie_act;
    cmd_e     cmd;
    lvl_e     lvl_q;
    lvl_e     lvl_d;

    assign hit_set = |(ev_strobe & set_mask);
    assign hit_clr = |(ev_strobe & clr_mask);
    assign tie_act = tie_act_e'(tie_field);

    // Command for this cycle: the tie action only matters on a collision
    always_comb begin
        cmd = CMD_HOLD;
        if (hit_set && hit_clr) begin
            unique case (tie_act)
                ACT_KEEP:   cmd = CMD_HOLD;
                ACT_HIGH:   cmd = CMD_SET;
                ACT_LOW:    cmd = CMD_CLEAR;
                ACT_INVERT: cmd = CMD_TOGGLE;
            endcase
        end else if (hit_set) begin
            cmd = CMD_SET;
        end else if (hit_clr) begin
            cmd = CMD_CLEAR;
        end
    end

    // Next-state: RAISE, DROP or HOLD
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW: begin
                if (cmd == CMD_SET || cmd == CMD_TOGGLE) lvl_d = LVL_HIGH;
            end
            LVL_HIGH: begin
                if (cmd == CMD_CLEAR || cmd == CMD_TOGGLE) lvl_d = LVL_LOW;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        unique case (lvl_q)
            LVL_LOW:  level = 1'b0;
            LVL_HIGH: level = 1'b1;
        endcase
    end

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_set && !hit_clr) |=> level) // R2
        else $error("set-only strobe did not raise output");

    AST_CLR_ONLY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_clr && !hit_set) |=> !level) // R3
        else $error("clear-only strobe did not drop output");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_set && !hit_clr) |=> $stable(level)) // R4
        else $error("output moved without a strobe");

    AST_TIE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_set && hit_clr && tie_field == 2'd3) |=> (level != $past(level))) // R5
        else $error("invert action did not flip output");

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(level)) // R6
        else $error("disabled output changed");

endmodule

// File: rtl/evo_setclr_unit.sv
module evo_setclr_unit
    import evo_pkg::*;
#(
    parameter int N_OUT = 16,
    parameter int N_EV  = 16,
    localparam int IDX_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int ADDR_W = IDX_W + 2,
    localparam int DATA_W = (2*N_OUT > N_EV) ? 2*N_OUT : N_EV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_EV-1:0]   ev_strobe,
    output logic [N_OUT-1:0]  pwm_out
);

    logic [N_OUT*N_EV-1:0] set_flat;
    logic [N_OUT*N_EV-1:0] clr_flat;
    logic [2*N_OUT-1:0]    tie_word;

    evo_regfile #(
        .N_OUT  (N_OUT),
        .N_EV   (N_EV),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_flat (set_flat),
        .clr_flat (clr_flat),
        .tie_word (tie_word)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        evo_chan #(
            .N_EV (N_EV)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_mask  (set_flat[i*N_EV +: N_EV]),
            .clr_mask  (clr_flat[i*N_EV +: N_EV]),
            .tie_field (tie_word[2*i +: 2]),
            .ev_strobe (ev_strobe),
            .level     (pwm_out[i])
        );
    end

endmodule

// File: tb/test_evo_setclr_unit.sv
module test_evo_setclr_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic [15:0] ev_strobe;
    logic [15:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    evo_setclr_unit i_evo_setclr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ev_strobe (ev_strobe),
        .pwm_out   (pwm_out)
    );

    // {strobe, expected outputs} under configuration A (see brief R2 R3 R4 R5 R6 R10)
    localparam logic [31:0] VEC [11] = '{
        {16'h0001, 16'h000F},
        {16'h0000, 16'h000F},
        {16'h0003, 16'h0005},
        {16'h0003, 16'h000D},
        {16'h0002, 16'h0000},
        {16'h0003, 16'h0009},
        {16'h0004, 16'h0019},
        {16'h000C, 16'h0019},
        {16'h0008, 16'h0009},
        {16'hFFF0, 16'h0009},
        {16'hFFFF, 16'h0001}
    };

    task automatic chk(input string tag, input logic [15:0] msk, input logic [15:0] exp);
        n_chk++;
        if ((pwm_out & msk) !== (exp & msk)) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, pwm_out & msk, exp & msk);
        end
    endtask

    task automatic wr_pulse(input logic [5:0] a, input logic [31:0] d, input logic [15:0] ev);
        wr_en = 1'b1; wr_addr = a; wr_data = d; ev_strobe = ev;
        @(negedge clk);
        wr_en = 1'b0; ev_strobe = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_pulse(a, d, 16'h0000);
    endtask

    task automatic pulse(input logic [15:0] ev);
        ev_strobe = ev;
        @(negedge clk);
        ev_strobe = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ev_strobe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 16'hFFFF, 16'h0000);

        // R1: tie field still 0 after reset, so a collision keeps level 0
        wr(6'd5, 32'h0020);
        wr(6'd21, 32'h0020);
        pulse(16'h0020);
        chk("R1 reset tie keeps level", 16'hFFFF, 16'h0000);

        // configuration A: outputs 0..3 set by ev0, cleared by ev1; output 4 ev2/ev3
        for (int k = 0; k < 4; k++) begin
            wr(6'(k), 32'h0001);
            wr(6'(16 + k), 32'h0002);
        end
        wr(6'd4, 32'h0004);
        wr(6'd20, 32'h0008);
        // ties: o0 high, o1 low, o2 keep, o3 invert, o6 high, o7 low
        wr(6'd32, 32'h0000_90C9);

        for (int v = 0; v < 11; v++) begin
            pulse(VEC[v][31:16]);
            chk($sformatf("R2 R3 R4 R5 R10 vector %0d", v), 16'h00FF, VEC[v][15:0]);
        end

        // R8 normal polarity on output 6: period ev0 sets, duty ev6 clears
        wr(6'd6, 32'h0001);
        wr(6'd22, 32'h0040);
        for (int p = 0; p < 3; p++) begin
            pulse(16'h0041);
            chk("R8 duty==period stays high", 16'h0040, 16'h0040);
        end
        pulse(16'h0040);
        chk("R8 duty alone drops", 16'h0040, 16'h0000);

        // R9 inverted polarity on output 7: duty ev7 sets, period ev0 clears
        wr(6'd7, 32'h0080);
        wr(6'd23, 32'h0001);
        pulse(16'h0080);
        chk("R9 duty alone raises", 16'h0080, 16'h0080);
        pulse(16'h0081);
        chk("R9 collision drops", 16'h0080, 16'h0000);
        pulse(16'h0081);
        chk("R9 collision stays low", 16'h0080, 16'h0000);

        // R7 write and strobe in the same cycle: old mask decides
        wr(6'd8, 32'h0100);
        wr(6'd24, 32'h0200);
        wr_pulse(6'd8, 32'h0000, 16'h0100);
        chk("R7 same-cycle write uses old mask", 16'h0100, 16'h0100);
        pulse(16'h0100);
        chk("R7 new mask applies next cycle", 16'h0100, 16'h0100);
        pulse(16'h0200);
        chk("R7 clear mask still active", 16'h0100, 16'h0000);

        // R7 unused region: tie word must not change (o0 high, o1 low on collision)
        wr(6'd48, 32'hFFFF_FFFF);
        pulse(16'h0003);
        chk("R7 unused region ignored", 16'h0003, 16'h0001);

        // R6 disable holds level
        pulse(16'h0004);
        chk("R2 output 4 raised", 16'h0010, 16'h0010);
        wr(6'd4, 32'h0000);
        wr(6'd20, 32'h0000);
        pulse(16'hFFFF);
        chk("R6 disabled output holds", 16'h0010, 16'h0010);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule